// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Receiver

This block turns a serial stereo audio stream into parallel left and right samples. The stream uses three lines: a bit clock, a channel-select (alignment) clock that marks which channel is on the wire, and one data line that is always an input. A 2-bit format input picks one of four framings. A 2-bit length input picks the sample width. When both words of a frame have arrived, the receiver presents them together with a one-cycle strobe.

In master mode the block makes the bit clock and the alignment clock itself, from the core clock. In slave mode it takes both clocks from outside. It passes them through synchronizers and samples the data on the rising edges of the external bit clock. The mode inputs are meant to change only while reset is held.

Top module: `audio_rx`

## Requirements
- R1: Data is taken most significant bit first. The length code is 00=16, 01=20, 10=24 and 11=32 bits. Each sample is shown MSB-aligned on a 32-bit output, with all bits below the word set to zero. Data bits on the line outside the word have no effect.
- R2: Format code 01 (left justified): a high alignment clock selects left. The MSB is the first bit sampled after an alignment-clock change.
- R3: Format code 10 (I2S): a low alignment clock selects left. The MSB comes one bit after the alignment-clock change. A 32-bit word whose LSB falls on the next change is still captured.
- R4: Format code 00 (right justified): a high alignment clock selects left. The LSB is the last bit sampled before the alignment-clock change.
- R5: Format code 11 (DSP): a one-bit-wide high alignment pulse marks a frame. The left word starts on the next bit and the right word follows it with no gap.
- R6: In right justified format, length code 11 is not allowed and is treated as 24 bits.
- R7: After the right word of a frame whose left word has already been captured, valid_o is high for exactly one core-clock cycle. left_o and right_o change only in that cycle and hold their values otherwise.
- R8: In master mode, bclk_o has a period of 4 core clocks (2 high, 2 low), and lrc_o changes only on a falling edge of bclk_o. In formats 00, 01 and 10, lrc_o toggles every 32 bit clocks. In format 11, lrc_o is high for one bit clock out of every 64.
- R9: In slave mode, bclk_o and lrc_o stay low. Data and alignment are sampled on rising edges of bclk_in.
- R10: While reset is held, every output is low. No word is captured until an alignment edge has been seen after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master | input | 1 | 1 = generate bit and alignment clocks, 0 = accept them |
| fmt | input | 2 | Framing: 00 right justified, 01 left justified, 10 I2S, 11 DSP |
| wlen | input | 2 | Word length: 00 16, 01 20, 10 24, 11 32 bits |
| bclk_in | input | 1 | External bit clock (slave mode) |
| lrc_in | input | 1 | External alignment clock (slave mode) |
| sdata | input | 1 | Serial audio data |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| lrc_o | output | 1 | Generated alignment clock (master mode) |
| left_o | output | 32 | Left sample, MSB-aligned |
| right_o | output | 32 | Right sample, MSB-aligned |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |

## Verification
The hardest cases to reach are the 32-bit I2S and DSP words. There, the final LSB lands on the very bit that carries the next alignment edge or pulse, so a design that restarts its bit position too early loses the last bit. The stimulus builds whole bit streams that keep slots exactly 32 bits wide. It then drives them with every format and every length, from outside clocks and from the block's own clocks, and fills all bits outside the words with random values. Every run begins with a partial slot that must not produce a sample. In I2S this slot is a right word with no left word before it.

// File: rtl/audio_rx.sv
`timescale 1ns/1ps
module audio_rx #(
  parameter int SLOT_BITS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        master,
  input  logic [1:0]  fmt,
  input  logic [1:0]  wlen,
  input  logic        bclk_in,
  input  logic        lrc_in,
  input  logic        sdata,
  output logic        bclk_o,
  output logic        lrc_o,
  output logic [31:0] left_o,
  output logic [31:0] right_o,
  output logic        valid_o
);
  localparam int CW = $clog2(2 * SLOT_BITS);
  localparam logic [1:0] F_RJ = 2'd0, F_LJ = 2'd1, F_I2S = 2'd2, F_DSP = 2'd3;

  logic [1:0]  div;
  logic [CW-1:0] bc;
  logic [SYNC_STAGES:0]   b_s;
  logic [SYNC_STAGES-1:0] l_s, d_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div <= '0;
      bc  <= '0;
      b_s <= '0;
      l_s <= '0;
      d_s <= '0;
    end else begin
      b_s <= {b_s[SYNC_STAGES-1:0], bclk_in};
      l_s <= {l_s[SYNC_STAGES-2:0], lrc_in};
      d_s <= {d_s[SYNC_STAGES-2:0], sdata};
      if (master) begin
        div <= div + 2'd1;
        if (div == 2'd3) bc <= bc + 1'b1;
      end
    end
  end

  assign bclk_o = master & div[1];
  assign lrc_o  = master & ((fmt == F_DSP) ? (bc == '1) : bc[CW-1]);

  logic bit_ev, lr_now, d_now;
  assign bit_ev = master ? (div == 2'd1) : (b_s[SYNC_STAGES-1] & ~b_s[SYNC_STAGES]);
  assign lr_now = master ? lrc_o : l_s[SYNC_STAGES-1];
  assign d_now  = master ? sdata : d_s[SYNC_STAGES-1];

  logic [5:0] nbits;
  always_comb begin
    case (wlen)
      2'd0:    nbits = 6'd16;
      2'd1:    nbits = 6'd20;
      2'd2:    nbits = 6'd24;
      default: nbits = (fmt == F_RJ) ? 6'd24 : 6'd32;
    endcase
  end

  logic        prev_lr, seen, lok;
  logic [6:0]  bp, bp_now;
  logic [7:0]  pp, n8;
  logic [31:0] sh, sh_nx, lhold, word, aligned;
  logic        edge_ev, cap, cap_r;

  assign n8      = {2'b00, nbits};
  assign edge_ev = (fmt == F_DSP) ? (lr_now & ~prev_lr) : (lr_now ^ prev_lr);
  assign pp      = {1'b0, bp} + 8'd1;
  assign bp_now  = edge_ev ? 7'd0 : ((bp == 7'h7f) ? bp : bp + 7'd1);
  assign sh_nx   = {sh[30:0], d_now};

  always_comb begin
    cap   = 1'b0;
    cap_r = 1'b0;
    word  = sh_nx;
    case (fmt)
      F_RJ: begin
        cap   = edge_ev & seen;
        cap_r = ~prev_lr;
        word  = sh;
      end
      F_LJ: begin
        cap   = (bp_now == n8[6:0] - 7'd1);
        cap_r = ~lr_now;
      end
      F_I2S: begin
        cap   = (pp == n8);
        cap_r = prev_lr;
      end
      default: begin
        cap   = (pp == n8) | (pp == {n8[6:0], 1'b0});
        cap_r = (pp == {n8[6:0], 1'b0});
      end
    endcase
  end

  assign aligned = word << (6'd32 - nbits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_lr <= 1'b0;
      seen    <= 1'b0;
      lok     <= 1'b0;
      bp      <= 7'h7f;
      sh      <= '0;
      lhold   <= '0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (bit_ev) begin
        prev_lr <= lr_now;
        bp      <= bp_now;
        sh      <= sh_nx;
        if (edge_ev) seen <= 1'b1;
        if (cap) begin
          if (!cap_r) begin
            lhold <= aligned;
            lok   <= 1'b1;
          end else if (lok) begin
            left_o  <= lhold;
            right_o <= aligned;
            valid_o <= 1'b1;
            lok     <= 1'b0;
          end
        end
      end
    end
  end
endmodule

module audio_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        master,
  input logic [1:0]  fmt,
  input logic [1:0]  wlen,
  input logic        bclk_o,
  input logic        lrc_o,
  input logic [31:0] left_o,
  input logic [31:0] right_o,
  input logic        valid_o
);
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));
  p_bclk_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (master && $rose(bclk_o)) |=> bclk_o);
  p_bclk_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (master && $fell(bclk_o)) |=> !bclk_o);
  p_lrc_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !$stable(lrc_o)) |-> $fell(bclk_o));
  p_zero_tail_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && wlen == 2'd0) |-> (left_o[15:0] == 16'd0 && right_o[15:0] == 16'd0));
  p_rj_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && fmt == 2'd0 && wlen == 2'd3) |-> (left_o[7:0] == 8'd0 && right_o[7:0] == 8'd0));
endmodule

bind audio_rx audio_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master(master), .fmt(fmt), .wlen(wlen),
  .bclk_o(bclk_o), .lrc_o(lrc_o), .left_o(left_o), .right_o(right_o),
  .valid_o(valid_o)
);

// File: tb/audio_rx_tb.sv
`timescale 1ns/1ps
module audio_rx_tb;
  localparam int NF = 3;
  localparam int NB = 320;

  logic clk = 1'b0, rst_n = 1'b0, master = 1'b0;
  logic [1:0] fmt = 2'd0, wlen = 2'd0;
  logic bclk_in = 1'b0, lrc_in = 1'b0, sdata = 1'b0;
  logic bclk_o, lrc_o, valid_o;
  logic [31:0] left_o, right_o;

  audio_rx u_dut (
    .clk(clk), .rst_n(rst_n), .master(master), .fmt(fmt), .wlen(wlen),
    .bclk_in(bclk_in), .lrc_in(lrc_in), .sdata(sdata),
    .bclk_o(bclk_o), .lrc_o(lrc_o), .left_o(left_o), .right_o(right_o),
    .valid_o(valid_o)
  );

  always #10 clk = ~clk;

  int checks = 0, errs = 0, quiet_bad = 0;
  logic armed = 1'b0, prev_valid = 1'b0;
  string cur_req = "R1";
  logic [63:0] exp_q[$];
  logic lr_a[0:NB-1];
  logic d_a[0:NB-1];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic void summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
  endfunction

  always @(negedge clk) begin
    if (rst_n && armed && valid_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R7", "unexpected valid", {left_o, right_o}, 64'd0);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk(left_o == e[63:32], cur_req, "left word (R1)", {32'd0, left_o}, {32'd0, e[63:32]});
        chk(right_o == e[31:0], cur_req, "right word (R1)", {32'd0, right_o}, {32'd0, e[31:0]});
      end
    end
    if (rst_n && armed && prev_valid)
      chk(!valid_o, "R7", "strobe width", {63'd0, valid_o}, 64'd0);
    if (rst_n && !master && (bclk_o || lrc_o)) quiet_bad++;
    prev_valid = rst_n & valid_o;
  end

  task automatic run_case(input bit m, input logic [1:0] f, input logic [1:0] w);
    int n, lm, rm, last;
    logic [31:0] lw, rw;
    armed = 1'b0; rst_n = 1'b0; master = m; fmt = f; wlen = w;
    bclk_in = 1'b0; lrc_in = 1'b0;
    n = (w == 2'd0) ? 16 : (w == 2'd1) ? 20 : (w == 2'd2) ? 24 : ((f == 2'd0) ? 24 : 32);
    cur_req = (f == 2'd0) ? ((w == 2'd3) ? "R6" : "R4") : (f == 2'd1) ? "R2" : (f == 2'd2) ? "R3" : "R5";
    for (int i = 0; i < NB; i++) begin
      lr_a[i] = (f == 2'd3) ? ((i % 64) == 63) : (((i / 32) % 2) == 1);
      d_a[i]  = 1'($urandom());
    end
    for (int fr = 0; fr < NF; fr++) begin
      lw = $urandom(); rw = $urandom();
      if (n < 32) begin
        lw = lw & ((32'd1 << n) - 32'd1);
        rw = rw & ((32'd1 << n) - 32'd1);
      end
      case (f)
        2'd0: begin lm = 64 + 64*fr - n; rm = 96 + 64*fr - n; end
        2'd1: begin lm = 32 + 64*fr; rm = 64 + 64*fr; end
        2'd2: begin lm = 65 + 64*fr; rm = 97 + 64*fr; end
        default: begin lm = 64 + 64*fr; rm = lm + n; end
      endcase
      for (int j = 0; j < n; j++) begin
        d_a[lm + j] = lw[n-1-j];
        d_a[rm + j] = rw[n-1-j];
      end
      exp_q.push_back({lw << (32 - n), rw << (32 - n)});
    end
    case (f)
      2'd0: last = 64*NF + 32;
      2'd1: last = 64*NF + n - 1;
      2'd2: last = 64*NF + 32 + n;
      default: last = 64*NF + 2*n;
    endcase
    sdata = d_a[0];
    lrc_in = m ? 1'b0 : lr_a[0];
    repeat (4) @(negedge clk);
    chk({bclk_o, lrc_o, valid_o, left_o, right_o} == '0, "R10", "outputs in reset",
        {29'd0, bclk_o, lrc_o, valid_o, left_o | right_o}, 64'd0);
    quiet_bad = 0;
    @(negedge clk);
    rst_n = 1'b1; armed = 1'b1;
    if (m) begin
      for (int i = 1; i <= last + 2; i++) begin
        @(negedge bclk_o);
        @(negedge clk);
        sdata = d_a[i];
      end
    end else begin
      for (int i = 0; i <= last + 2; i++) begin
        @(negedge clk);
        lrc_in = lr_a[i]; sdata = d_a[i]; bclk_in = 1'b0;
        repeat (3) @(negedge clk);
        bclk_in = 1'b1;
        repeat (4) @(negedge clk);
      end
      bclk_in = 1'b0;
    end
    repeat (12) @(negedge clk);
    chk(exp_q.size() == 0, cur_req, "frames still expected (R7)", 64'(exp_q.size()), 64'd0);
    if (!m) chk(quiet_bad == 0, "R9", "clock outputs in slave mode", 64'(quiet_bad), 64'd0);
    armed = 1'b0;
    exp_q.delete();
    rst_n = 1'b0;
  endtask

  task automatic clock_test();
    time t0, t1, t2;
    armed = 1'b0; rst_n = 1'b0; master = 1'b1; fmt = 2'd1; wlen = 2'd0; sdata = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge bclk_o); t0 = $time;
    @(negedge bclk_o); t1 = $time;
    @(posedge bclk_o); t2 = $time;
    chk((t2 - t0) == 80, "R8", "bit clock period ns", 64'(t2 - t0), 64'd80);
    chk((t1 - t0) == 40, "R8", "bit clock high ns", 64'(t1 - t0), 64'd40);
    @(posedge lrc_o); t0 = $time;
    @(negedge lrc_o); t1 = $time;
    chk((t1 - t0) == 2560, "R8", "alignment half frame ns", 64'(t1 - t0), 64'd2560);
    rst_n = 1'b0; fmt = 2'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge lrc_o); t0 = $time;
    @(negedge lrc_o); t1 = $time;
    @(posedge lrc_o); t2 = $time;
    chk((t1 - t0) == 80, "R8", "DSP pulse width ns", 64'(t1 - t0), 64'd80);
    chk((t2 - t0) == 5120, "R8", "DSP pulse spacing ns", 64'(t2 - t0), 64'd5120);
    rst_n = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    clock_test();
    for (int f = 0; f < 4; f++)
      for (int w = 0; w < 4; w++)
        run_case(1'b0, 2'(f), 2'(w));
    for (int f = 0; f < 4; f++) begin
      run_case(1'b1, 2'(f), 2'd3);
      run_case(1'b1, 2'(f), 2'd0);
    end
    summary();
    $finish;
  end
endmodule